// File: doc/BRIEF.md
# Asynchronous Serial Transmit Framer

This block turns bytes into asynchronous serial frames on a single output line. A byte arrives over a valid strobe into a one-entry holding register. When the shifter is free, the byte moves into it and goes out as a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period. An upstream baud generator supplies a strobe at sixteen times the bit rate. The line idles high.

The frame format comes from a line-control byte. Bits [1:0] give the word length, bit 2 extends the stop period, bit 3 enables parity, bit 4 picks even parity, bit 5 forces a fixed parity value, and bit 6 holds the line low as a break. Bit 7 is unused. The format fields are captured when a frame starts. The break bit acts on the output line at once and leaves the shifter running. Two flags report progress: one shows that the holding register can take a byte, and one shows that the whole transmit path has gone quiet. Software can clear a break cleanly once the second flag is set.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd_o` is 1, and `hold_empty_o` and `tx_empty_o` are both 1.
- R2: A byte on `tx_data_i` is accepted on a clock edge where `tx_valid_i` is 1 and `hold_empty_o` is 1, and `hold_empty_o` is 0 in the next cycle. A strobe while `hold_empty_o` is 0 is ignored and does not replace the held byte.
- R3: A frame starts with a 0 start bit, followed by the data bits, least significant bit first. The count of data bits is set by `lcr_i[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Each bit lasts 16 `baud_tick_i` pulses.
- R4: With `lcr_i[3]`=1 and `lcr_i[5]`=0, one parity bit follows the data. With `lcr_i[4]`=1, this bit makes the count of ones over data plus parity even. With `lcr_i[4]`=0, it makes that count odd.
- R5: With `lcr_i[3]`=1 and `lcr_i[5]`=1, the parity bit equals the inverse of `lcr_i[4]`, whatever the data.
- R6: The stop period is high and lasts 16 ticks when `lcr_i[2]`=0. When `lcr_i[2]`=1 it lasts 32 ticks, or 24 ticks when the word length is 5.
- R7: While `lcr_i[6]` is 1, `txd_o` is 0 in the same cycle. The frame timing and the flags are unchanged by the break.
- R8: `tx_empty_o` is 1 only when the holding register is empty and the shifter is idle. It rises in the cycle after the tick that ends the stop period.
- R9: A byte waiting in the holding register starts its frame one clock after the previous frame ends, and `tx_empty_o` stays 0 across that boundary.
- R10: The shifter advances only on cycles where `baud_tick_i` is 1. With no ticks, the line stays in its current bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Strobe at 16 times the bit rate |
| lcr_i | input | 8 | Line-control byte: format fields and break |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Write strobe for `tx_data_i` |
| txd_o | output | 1 | Serial output line |
| hold_empty_o | output | 1 | Holding register can accept a byte |
| tx_empty_o | output | 1 | Holding register and shifter both idle |

## Verification
Two events can fall on the same cycle. The shifter can be finishing its stop period while the holding register already holds the next byte. In that case the handoff must empty the register and restart the shifter with no gap on `tx_empty_o`. The bench provokes this by writing a second byte while the first frame is still on the line, then sending a third strobe that must be ignored. It then checks three things: `tx_empty_o` stays low at the boundary, the second start bit begins exactly one clock after the first stop period ends, and the second frame carries the second byte rather than the third.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PARITY,
      PH_STOP
   } tx_phase_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       long_stop;
      logic       par_en;
      logic       par_even;
      logic       par_fixed;
   } frame_cfg_t;

   function automatic frame_cfg_t cfg_from_lcr(input logic [7:0] lcr);
      frame_cfg_t c;
      c.wlen      = lcr[1:0];
      c.long_stop = lcr[2];
      c.par_en    = lcr[3];
      c.par_even  = lcr[4];
      c.par_fixed = lcr[5];
      return c;
   endfunction

   function automatic logic [3:0] word_bits(input logic [1:0] wlen);
      return 4'd5 + {2'b00, wlen};
   endfunction

   function automatic logic [7:0] mask_word(input logic [7:0] d, input logic [1:0] wlen);
      logic [7:0] m;
      for (int i = 0; i < 8; i++) m[i] = d[i] & (4'(i) < word_bits(wlen));
      return m;
   endfunction

   function automatic logic parity_of(input frame_cfg_t c, input logic [7:0] dm);
      if (c.par_fixed) return ~c.par_even;
      return c.par_even ? ^dm : ~^dm;
   endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              take_i,
   output logic [WORD_W-1:0] data_o,
   output logic              empty_o
);
   logic              full_q;
   logic [WORD_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (take_i) begin
         full_q <= 1'b0;
      end else if (wr_valid_i && !full_q) begin
         full_q <= 1'b1;
         data_q <= wr_data_i;
      end
   end

   assign data_o  = data_q;
   assign empty_o = !full_q;
endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] last_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;

   assign done_o = tick_i && (cnt_q == last_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clear_i)  cnt_q <= '0;
      else if (done_o)   cnt_q <= '0;
      else if (tick_i)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
   import uart_tx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [7:0] data_i,
   input  frame_cfg_t cfg_i,
   input  logic       tick_i,
   output logic       busy_o,
   output logic       line_o
);
   localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
   localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(TICKS_PER_BIT - 1);
   localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'((3 * TICKS_PER_BIT) / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

   tx_phase_e        phase_q;
   frame_cfg_t       cfg_q;
   logic [7:0]       sh_q;
   logic [3:0]       left_q;
   logic             par_q;
   logic [CNT_W-1:0] last;
   logic             done;

   always_comb begin
      last = LAST_ONE;
      if (phase_q == PH_STOP && cfg_q.long_stop)
         last = (cfg_q.wlen == 2'b00) ? LAST_HALF : LAST_TWO;
   end

   uart_tx_bit_timer #(.CNT_W(CNT_W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(load_i),
      .tick_i (tick_i && busy_o),
      .last_i (last),
      .done_o (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cfg_q   <= '0;
         sh_q    <= '0;
         left_q  <= '0;
         par_q   <= 1'b0;
      end else if (load_i) begin
         phase_q <= PH_START;
         cfg_q   <= cfg_i;
         sh_q    <= mask_word(data_i, cfg_i.wlen);
         left_q  <= word_bits(cfg_i.wlen);
         par_q   <= parity_of(cfg_i, mask_word(data_i, cfg_i.wlen));
      end else if (done) begin
         unique case (phase_q)
            PH_START:  phase_q <= PH_DATA;
            PH_DATA: begin
               sh_q   <= sh_q >> 1;
               left_q <= left_q - 1'b1;
               if (left_q == 4'd1) phase_q <= cfg_q.par_en ? PH_PARITY : PH_STOP;
            end
            PH_PARITY: phase_q <= PH_STOP;
            PH_STOP:   phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (phase_q)
         PH_START:  line_o = 1'b0;
         PH_DATA:   line_o = sh_q[0];
         PH_PARITY: line_o = par_q;
         default:   line_o = 1'b1;
      endcase
   end

   assign busy_o = (phase_q != PH_IDLE);
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int TICKS_PER_BIT    = 16,
   parameter bit BREAK_REGISTERED = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick_i,
   input  logic [7:0] lcr_i,
   input  logic [7:0] tx_data_i,
   input  logic       tx_valid_i,
   output logic       txd_o,
   output logic       hold_empty_o,
   output logic       tx_empty_o
);
   if (TICKS_PER_BIT < 2 || (TICKS_PER_BIT % 2) != 0) begin : g_bad_ticks
      $error("TICKS_PER_BIT must be even and at least 2");
   end

   logic [7:0] held_data;
   logic       take;
   logic       shift_busy;
   logic       shift_line;
   logic       brk;

   assign take = hold_empty_o == 1'b0 && !shift_busy;
   assign brk  = lcr_i[6];

   uart_tx_hold #(.WORD_W(8)) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid_i(tx_valid_i),
      .wr_data_i (tx_data_i),
      .take_i    (take),
      .data_o    (held_data),
      .empty_o   (hold_empty_o)
   );

   uart_tx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(take),
      .data_i(held_data),
      .cfg_i (cfg_from_lcr(lcr_i)),
      .tick_i(baud_tick_i),
      .busy_o(shift_busy),
      .line_o(shift_line)
   );

   if (BREAK_REGISTERED) begin : g_brk_reg
      logic txd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) txd_q <= 1'b1;
         else        txd_q <= shift_line & ~brk;
      end
      assign txd_o = txd_q;
   end else begin : g_brk_comb
      assign txd_o = shift_line & ~brk;
   end

   assign tx_empty_o = hold_empty_o && !shift_busy;
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk #(
   parameter bit BREAK_REG = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       baud_tick_i,
   input logic [7:0] lcr_i,
   input logic       tx_valid_i,
   input logic       txd_o,
   input logic       hold_empty_o,
   input logic       tx_empty_o,
   input logic       shift_busy,
   input logic       shift_line
);
   if (BREAK_REG) begin : g_reg
      assert_break_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
         lcr_i[6] |=> !txd_o);
   end else begin : g_comb
      assert_break_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
         lcr_i[6] |-> !txd_o);
      assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_empty_o && !lcr_i[6]) |-> txd_o);
   end

   assert_empty_needs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty_o |-> hold_empty_o);

   assert_accept_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_empty_o) |-> $past(tx_valid_i));

   assert_handoff_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty_o) |-> (shift_busy && !tx_empty_o));

   assert_gated_by_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_busy && $past(shift_busy) && !$past(baud_tick_i)) |-> $stable(shift_line));
endmodule

bind uart_tx_framer uart_tx_framer_chk #(.BREAK_REG(BREAK_REGISTERED)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .baud_tick_i (baud_tick_i),
   .lcr_i       (lcr_i),
   .tx_valid_i  (tx_valid_i),
   .txd_o       (txd_o),
   .hold_empty_o(hold_empty_o),
   .tx_empty_o  (tx_empty_o),
   .shift_busy  (shift_busy),
   .shift_line  (shift_line)
);

// File: tb/test_uart_tx_framer.sv
module test_uart_tx_framer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic [7:0] lcr = 8'h03;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       txd, hold_empty, tx_empty;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;

   always #2.5 clk = ~clk;

   uart_tx_framer i_uart_tx_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .baud_tick_i (baud_tick),
      .lcr_i       (lcr),
      .tx_data_i   (tx_data),
      .tx_valid_i  (tx_valid),
      .txd_o       (txd),
      .hold_empty_o(hold_empty),
      .tx_empty_o  (tx_empty)
   );

   function automatic int n_bits(input logic [7:0] l);
      return 5 + int'(l[1:0]);
   endfunction

   function automatic int stop_ticks(input logic [7:0] l);
      if (!l[2]) return 16;
      return (l[1:0] == 2'b00) ? 24 : 32;
   endfunction

   function automatic int body_ticks(input logic [7:0] l);
      return 16 * (1 + n_bits(l) + int'(l[3]));
   endfunction

   function automatic logic exp_bit(input logic [7:0] d, input logic [7:0] l, input int slot);
      logic [7:0] dm;
      int n;
      n = n_bits(l);
      dm = 8'h00;
      for (int i = 0; i < n; i++) dm[i] = d[i];
      if (slot == 0) return 1'b0;
      if (slot <= n) return dm[slot-1];
      if (l[5]) return ~l[4];
      return l[4] ? ^dm : ~^dm;
   endfunction

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic put_byte(input logic [7:0] d);
      @(negedge clk);
      tx_data  = d;
      tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      chk(hold_empty, 1'b0, "R2", "hold flag after write");
   endtask

   // Called just before the negedge that shows the start bit (index 0).
   task automatic watch_frame(input logic [7:0] d, input logic [7:0] l, input bit more);
      int body, total;
      body  = body_ticks(l);
      total = body + stop_ticks(l);
      for (int k = 0; k <= total; k++) begin
         @(negedge clk);
         if (k == 0) chk(hold_empty, 1'b1, "R2", "hold flag after handoff");
         if (k < body && (k % 16) == 8) begin
            int slot;
            slot = k / 16;
            if (l[6])
               chk(txd, 1'b0, "R7", "break holds line");
            else if (slot > n_bits(l))
               chk(txd, exp_bit(d, l, slot), l[5] ? "R5" : "R4", "parity bit");
            else
               chk(txd, exp_bit(d, l, slot), "R3", "start or data bit");
         end
         if (k >= body && k < total) chk(txd, ~l[6], l[6] ? "R7" : "R6", "stop period");
         if (k == total - 1) chk(tx_empty, 1'b0, "R6", "busy through last stop tick");
         if (k == total)     chk(tx_empty, !more, more ? "R9" : "R8", "empty flag after frame");
      end
   endtask

   task automatic run_frame(input logic [7:0] d, input logic [7:0] l);
      lcr = l;
      put_byte(d);
      watch_frame(d, l, 1'b0);
      @(negedge clk);
      chk(txd, ~l[6], "R1", "idle level after frame");
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL R8 watchdog expired: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20517));
      repeat (3) @(negedge clk);
      chk(txd, 1'b1, "R1", "reset line");
      chk(hold_empty, 1'b1, "R1", "reset hold flag");
      chk(tx_empty, 1'b1, "R1", "reset empty flag");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(txd, 1'b1, "R1", "idle after reset");

      // Directed formats
      run_frame(8'hA5, 8'b0000_0011);          // 8N1
      run_frame(8'h1F, 8'b0000_0000);          // 5N1
      run_frame(8'h96, 8'b0000_1011);          // 8 bits odd parity
      run_frame(8'h96, 8'b0001_1011);          // 8 bits even parity
      run_frame(8'h3C, 8'b0011_1010);          // stick, even select set -> 0
      run_frame(8'h3C, 8'b0010_1001);          // stick, even select clear -> 1
      run_frame(8'h0A, 8'b0000_0100);          // 5 bits, 1.5 stop
      run_frame(8'h2B, 8'b0000_0101);          // 6 bits, 2 stop
      run_frame(8'h55, 8'b0100_1111);          // break over a full frame
      lcr = 8'h03;

      // Break at idle
      @(negedge clk); lcr = 8'h43;
      @(negedge clk); chk(txd, 1'b0, "R7", "break at idle");
      chk(tx_empty, 1'b1, "R7", "break leaves flags");
      lcr = 8'h03;
      @(negedge clk); chk(txd, 1'b1, "R7", "break released");

      // No ticks: the start bit persists
      baud_tick = 1'b0;
      put_byte(8'hFF);
      repeat (40) @(negedge clk);
      chk(txd, 1'b0, "R10", "start bit held without ticks");
      chk(tx_empty, 1'b0, "R10", "still busy without ticks");
      baud_tick = 1'b1;
      while (!tx_empty) @(negedge clk);
      chk(txd, 1'b1, "R10", "line idle after resumed frame");

      // Overlap: second byte waits, third strobe ignored
      lcr = 8'h1B;
      put_byte(8'hC3);
      fork
         watch_frame(8'hC3, 8'h1B, 1'b1);
         begin
            @(negedge clk);
            tx_data = 8'h5A; tx_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
            @(negedge clk);
            tx_data = 8'hE1; tx_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
            chk(hold_empty, 1'b0, "R2", "held byte kept while full");
         end
      join
      watch_frame(8'h5A, 8'h1B, 1'b0);
      @(negedge clk);

      // Random formats and data
      for (int n = 0; n < 30; n++) begin
         logic [7:0] l, d;
         l = 8'($urandom) & 8'h3F;
         d = 8'($urandom);
         run_frame(d, l);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule